// File: doc/BRIEF.md
# Dual-Clock FIFO with Encoded Fill Flags

This block is a first-in first-out buffer with separate write and read clocks. It holds 512 words of 9 bits. A producer pushes one word on every write-clock edge while its enable is high. A consumer pulls one word through an output register on every read-clock edge while its enable is high. The two clocks may run unrelated to each other or be tied together, and reads and writes may happen in the same cycle.

Occupancy is reported on a two-bit code rather than on separate full and empty lines. The read domain owns the two empty-side codes and the write domain owns the nearly-full code. Pointers cross between the domains as Gray values through two-flop synchronisers. The code can therefore lag the true fill level, but it always errs toward the safe side.

An optional parity mode uses the ninth bit. When the mode is on at write time, the block generates parity. When the mode is on at read time, the block checks it.

Top module: `flagged_async_fifo`

## Requirements
- R1: Each write-clock edge with `wr_en` high and the buffer not full stores `wr_data`. Words leave in the order they were stored, with all 9 bits intact.
- R2: A read-clock edge with `rd_en` high while `fill_code` is not 00 loads the oldest word into `rd_data`. `rd_data` holds its value on every other read-clock edge.
- R3: A write attempted while 512 words are stored is dropped, and the stored words and their order are unchanged.
- R4: A read attempted while `fill_code` reads 00 leaves `rd_data`, `par_err` and the stored words unchanged.
- R5: Once settled, `fill_code` is 00 for an empty buffer, 01 for 1 to 16 words, 11 for 496 or more words, and 10 for any other level. The empty-side codes take priority over 11.
- R6: The code is never optimistic. With both clocks tied, a write into an empty buffer moves `fill_code` from 00 to 01 on the third clock edge after the write edge. Each pointer's Gray value changes by at most one bit per edge.
- R7: `mrst` high clears both pointers and forces `fill_code` to 00, `rd_data` to 0 and `par_err` to 0. After `mrst` is released, only words written afterwards are read out.
- R8: With `par_mode` high at write time, bit 8 is stored as the XOR of `wr_data[7:0]`, which gives even parity over the 9-bit word, and `wr_data[8]` is discarded.
- R9: On each read, `par_err` becomes 1 if `par_mode` is high and stored bit 8 differs from the XOR of stored bits 7..0. Otherwise `par_err` becomes 0.
- R10: Reads and writes running in the same cycles keep the stream in order, with no word lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_en | input | 1 | Store `wr_data` on this write edge |
| wr_data | input | 9 | Word to store |
| rd_clk | input | 1 | Read-domain clock |
| rd_en | input | 1 | Pull one word on this read edge |
| rd_data | output | 9 | Registered output word |
| par_mode | input | 1 | Parity generate and check enable |
| mrst | input | 1 | Asynchronous master reset, active high |
| fill_code | output | 2 | Fill state: 00 empty, 01 low, 10 middle, 11 high |
| par_err | output | 1 | Parity mismatch on the last word read |

## Verification
With the clocks tied, a word read on an edge appears on `rd_data` and `par_err` after that same edge. The monitor decides whether a read took place from `rd_en` and `fill_code` sampled half a cycle before the edge, and it compares the result half a cycle after the edge. A write reaches the empty-side code three edges later: the source Gray register, two synchroniser stages and the flag register. The latency test samples `fill_code` at each of those three edges. The level tests wait several cycles after the last write so that both domains have settled before the code is compared.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  typedef enum logic [1:0] {
    FILL_EMPTY = 2'b00,
    FILL_LOW   = 2'b01,
    FILL_MID   = 2'b10,
    FILL_HIGH  = 2'b11
  } fill_e;

  // Read-domain states win over the write-domain high state.
  function automatic fill_e fill_encode(input logic empty_q, input logic low_q,
                                        input logic high_q);
    if (empty_q)     return FILL_EMPTY;
    else if (low_q)  return FILL_LOW;
    else if (high_q) return FILL_HIGH;
    else             return FILL_MID;
  endfunction

endpackage

// File: rtl/dcf_ptr_xfer.sv
module dcf_ptr_xfer #(
  parameter int PW = 10
) (
  input  logic          dst_clk,
  input  logic          rst,
  input  logic [PW-1:0] src_gray,
  output logic [PW-1:0] dst_bin
);
  logic [PW-1:0] stage1, stage2;

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_ff @(posedge dst_clk or posedge rst) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= src_gray;
      stage2 <= stage1;
    end
  end

  assign dst_bin = from_gray(stage2);
endmodule

// File: rtl/dcf_store.sv
module dcf_store #(
  parameter int AW = 9,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side #(
  parameter int AW      = 9,
  parameter int HIGH_TH = 496
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [AW:0] rq_bin,
  output logic [AW:0] wgray,
  output logic [AW-1:0] waddr,
  output logic        wr_fire,
  output logic        high_q
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);
  localparam logic [PW-1:0] HIGH_P  = PW'(HIGH_TH);

  logic [PW-1:0] wptr, wptr_next, lvl_next, lvl_now;
  logic          full_q;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  assign wr_fire   = wr_en && !full_q;
  assign wptr_next = wptr + PW'(wr_fire);
  assign lvl_next  = wptr_next - rq_bin;
  assign lvl_now   = wptr - rq_bin;
  assign waddr     = wptr[AW-1:0];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wptr   <= '0;
      wgray  <= '0;
      full_q <= 1'b0;
      high_q <= 1'b0;
    end else begin
      wptr   <= wptr_next;
      wgray  <= to_gray(wptr_next);
      full_q <= (lvl_next == DEPTH_P);
      high_q <= (lvl_next >= HIGH_P);
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    lvl_now <= DEPTH_P);
  a_r1_ptr_step: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> (wptr == $past(wptr) + PW'(1)));
  a_r6_wgray_step: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wgray ^ $past(wgray)));
  a_r5_full_is_high: assert property (@(posedge clk) disable iff (rst)
    full_q |-> high_q);
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side #(
  parameter int AW     = 9,
  parameter int DW     = 9,
  parameter int LOW_TH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          par_mode,
  input  logic [AW:0]   wq_bin,
  input  logic [DW-1:0] mem_q,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] rd_data,
  output logic          par_err,
  output logic          empty_q,
  output logic          low_q
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);
  localparam logic [PW-1:0] LOW_P   = PW'(LOW_TH);

  logic [PW-1:0] rptr, rptr_next, lvl_next, lvl_now;
  logic          rd_fire, mismatch;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  assign rd_fire   = rd_en && !empty_q;
  assign rptr_next = rptr + PW'(rd_fire);
  assign lvl_next  = wq_bin - rptr_next;
  assign lvl_now   = wq_bin - rptr;
  assign raddr     = rptr[AW-1:0];
  assign mismatch  = mem_q[DW-1] != (^mem_q[DW-2:0]);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rptr    <= '0;
      rgray   <= '0;
      rd_data <= '0;
      par_err <= 1'b0;
      empty_q <= 1'b1;
      low_q   <= 1'b0;
    end else begin
      rptr    <= rptr_next;
      rgray   <= to_gray(rptr_next);
      empty_q <= (lvl_next == '0);
      low_q   <= (lvl_next != '0) && (lvl_next <= LOW_P);
      if (rd_fire) begin
        rd_data <= mem_q;
        par_err <= par_mode && mismatch;
      end
    end
  end

  a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
    rd_fire |-> (wq_bin != rptr));
  a_r4_level_bound: assert property (@(posedge clk) disable iff (rst)
    lvl_now <= DEPTH_P);
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_fire |=> ($stable(rd_data) && $stable(par_err)));
  a_r6_rgray_step: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rgray ^ $past(rgray)));
  a_r9_err_needs_mode: assert property (@(posedge clk) disable iff (rst)
    $rose(par_err) |-> $past(par_mode));
endmodule

// File: rtl/flagged_async_fifo.sv
module flagged_async_fifo
  import dcf_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int ADDR_W  = 9,
  parameter int LOW_TH  = 16,
  parameter int HIGH_TH = 496
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              par_mode,
  input  logic              mrst,
  output logic [1:0]        fill_code,
  output logic              par_err
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0]     wgray, rgray, wq_bin, rq_bin;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [DATA_W-1:0] store_word, mem_q;
  logic              wr_fire, empty_q, low_q, high_q;

  function automatic logic [DATA_W-1:0] with_parity(input logic [DATA_W-1:0] d,
                                                    input logic gen);
    return gen ? {^d[DATA_W-2:0], d[DATA_W-2:0]} : d;
  endfunction

  assign store_word = with_parity(wr_data, par_mode);

  dcf_wr_side #(.AW(ADDR_W), .HIGH_TH(HIGH_TH)) u_wr (
    .clk(wr_clk), .rst(mrst), .wr_en(wr_en), .rq_bin(rq_bin),
    .wgray(wgray), .waddr(waddr), .wr_fire(wr_fire), .high_q(high_q)
  );

  dcf_store #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk(wr_clk), .we(wr_fire), .waddr(waddr), .wdata(store_word),
    .raddr(raddr), .rdata(mem_q)
  );

  dcf_ptr_xfer #(.PW(PW)) u_w2r (
    .dst_clk(rd_clk), .rst(mrst), .src_gray(wgray), .dst_bin(wq_bin)
  );

  dcf_ptr_xfer #(.PW(PW)) u_r2w (
    .dst_clk(wr_clk), .rst(mrst), .src_gray(rgray), .dst_bin(rq_bin)
  );

  dcf_rd_side #(.AW(ADDR_W), .DW(DATA_W), .LOW_TH(LOW_TH)) u_rd (
    .clk(rd_clk), .rst(mrst), .rd_en(rd_en), .par_mode(par_mode),
    .wq_bin(wq_bin), .mem_q(mem_q), .raddr(raddr), .rgray(rgray),
    .rd_data(rd_data), .par_err(par_err), .empty_q(empty_q), .low_q(low_q)
  );

  assign fill_code = fill_encode(empty_q, low_q, high_q);

  a_r5_empty_not_low: assert property (@(posedge rd_clk) disable iff (mrst)
    !(empty_q && low_q));
endmodule

// File: tb/tb_flagged_async_fifo.sv
module tb_flagged_async_fifo;
  logic       clk = 1'b0;
  logic       mrst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, par_mode = 1'b0;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_data;
  logic [1:0] fill_code;
  logic       par_err;

  int  n_chk = 0, n_err = 0;
  bit  done = 0;
  logic [8:0] exp_q[$];

  always #10 clk = ~clk;

  flagged_async_fifo dut (
    .wr_clk(clk), .wr_en(wr_en), .wr_data(wr_data),
    .rd_clk(clk), .rd_en(rd_en), .rd_data(rd_data),
    .par_mode(par_mode), .mrst(mrst), .fill_code(fill_code), .par_err(par_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // Driver: each word written is pushed with the value expected back.
  task automatic wr_words(input int n, input int seed, input bit push);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      wr_en   = 1'b1;
      wr_data = 9'(seed + i * 37);
      if (push) exp_q.push_back(par_mode ? {^wr_data[7:0], wr_data[7:0]} : wr_data);
    end
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_reset();
    @(posedge clk); #2;
    mrst = 1'b1;
    exp_q.delete();
    repeat (3) @(posedge clk);
    #2 mrst = 1'b0;
  endtask

  // Monitor: a read happens on an edge where rd_en was high and the code not 00.
  bit         fire_prev = 0, mode_prev = 0;
  logic [8:0] last_q = '0;
  always @(negedge clk) begin
    if (mrst) begin
      fire_prev = 0;
      last_q    = rd_data;
    end else begin
      if (fire_prev) begin
        if (exp_q.size() == 0) chk(0, "R4 read taken with nothing stored", rd_data, 0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk(rd_data === e, "R1/R2/R8/R10 word read", rd_data, e);
          chk(par_err === (mode_prev && (e[8] != ^e[7:0])), "R9 parity flag",
              par_err, mode_prev && (e[8] != ^e[7:0]));
        end
      end else begin
        chk(rd_data === last_q, "R2/R4 output held", rd_data, last_q);
      end
      last_q    = rd_data;
      fire_prev = rd_en && (fill_code != 2'b00);
      mode_prev = par_mode;
    end
  end

  initial begin
    #(20 * 150000);
    chk(0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 mrst = 1'b0;
    @(negedge clk);
    // R7: reset state
    chk(fill_code === 2'b00, "R7 code after reset", fill_code, 0);
    chk(rd_data === 9'h000, "R7 rd_data after reset", rd_data, 0);
    chk(par_err === 1'b0, "R7 par_err after reset", par_err, 0);

    // R6: flag latency of three edges, never early
    wr_words(1, 3, 1);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk(fill_code === 2'b00, "R6 code still empty", fill_code, 0);
    end
    @(negedge clk);
    chk(fill_code === 2'b01, "R6 code low on third edge", fill_code, 1);

    // R5: thresholds
    wr_words(15, 11, 1); settle();
    chk(fill_code === 2'b01, "R5 16 words low", fill_code, 1);
    wr_words(1, 19, 1); settle();
    chk(fill_code === 2'b10, "R5 17 words middle", fill_code, 2);
    wr_words(478, 23, 1); settle();
    chk(fill_code === 2'b10, "R5 495 words middle", fill_code, 2);
    wr_words(1, 29, 1); settle();
    chk(fill_code === 2'b11, "R5 496 words high", fill_code, 3);
    wr_words(16, 31, 1);
    // R3: extra writes while full are dropped (not pushed)
    wr_words(3, 400, 0); settle();
    chk(fill_code === 2'b11, "R3 full stays high", fill_code, 3);

    // Drain: monitor checks every word; then reads on empty do nothing (R4)
    @(posedge clk); #2 rd_en = 1'b1;
    repeat (540) @(posedge clk);
    settle();
    chk(fill_code === 2'b00, "R4/R5 drained to empty", fill_code, 0);
    chk(exp_q.size() == 0, "R3 exactly 512 words out", exp_q.size(), 0);

    // R10: streaming with reads and writes together
    wr_words(40, 101, 1);
    repeat (20) @(posedge clk);
    settle();
    chk(exp_q.size() == 0, "R10 stream fully delivered", exp_q.size(), 0);
    @(posedge clk); #2 rd_en = 1'b0;

    // R8: parity generated on write, no error on read
    par_mode = 1'b1;
    wr_words(8, 300, 1); settle();
    @(posedge clk); #2 rd_en = 1'b1;
    repeat (20) @(posedge clk);
    #2 rd_en = 1'b0;
    chk(exp_q.size() == 0, "R8 parity words delivered", exp_q.size(), 0);

    // R9: raw words stored, checked on read with mode on
    par_mode = 1'b0;
    wr_words(8, 77, 1); settle();
    par_mode = 1'b1;
    @(posedge clk); #2 rd_en = 1'b1;
    repeat (20) @(posedge clk);
    #2 rd_en = 1'b0;
    par_mode = 1'b0;
    chk(exp_q.size() == 0, "R9 checked words delivered", exp_q.size(), 0);

    // R7: reset mid-run discards stored words
    wr_words(5, 200, 1); settle();
    pulse_reset();
    @(negedge clk);
    chk(fill_code === 2'b00, "R7 code after mid reset", fill_code, 0);
    chk(par_err === 1'b0, "R7 par_err after mid reset", par_err, 0);
    wr_words(2, 250, 1); settle();
    @(posedge clk); #2 rd_en = 1'b1;
    repeat (10) @(posedge clk);
    #2 rd_en = 1'b0;
    settle();
    chk(exp_q.size() == 0 && fill_code === 2'b00, "R7 only new words read",
        exp_q.size(), 0);
    report();
  end
endmodule